// File: doc/BRIEF.md
# Stereo Audio Serial Receiver (Clock Follower)

This block receives a two-channel audio stream from an external transmitter that owns the bit clock and the word-select line. All three incoming lines pass through synchronizers into the local system clock domain. A rising bit-clock edge is detected there, and the block samples word select and data at that edge. A frame counter follows the stream. The run-time format input decides which bit-clock positions carry sample bits, so four framing conventions share one datapath. Sample bits arrive MSB first.

At the end of each right-channel sample, the left and right words are sign-extended to the output width and presented together with a one-cycle strobe. Every frame is measured in bit clocks and compared with twice the slot width. A frame that is too short or too long raises a sticky error flag, and output stops until a whole frame of the right length has been observed. The local clock must run at least four times faster than the bit clock.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `valid_o` and `sync_err_o` are low and both sample outputs are zero.
- R2: With `fmt_i`=0 (standard), a frame starts one bit clock after word select falls. Word select low carries the left sample and high carries the right sample. The MSB of each sample is taken one bit clock after the word-select change, and the following bits come MSB first.
- R3: With `fmt_i`=1 (left-justified), the MSB of each sample is taken on the same bit clock where the new word-select level is first seen.
- R4: With `fmt_i`=2 (right-justified), each half-frame keeps only its final SAMPLE_W bits. The SLOT_W−SAMPLE_W leading padding bits are discarded whatever their values.
- R5: With `fmt_i`=3 (short sync), a frame starts on the bit clock after the one in which the one-bit-clock sync pulse on word select is high. The left sample is the first SAMPLE_W bits of the frame. The right sample is the first SAMPLE_W bits starting at bit SLOT_W.
- R6: Each accepted stereo pair appears on `left_o` and `right_o` with a `valid_o` pulse of exactly one cycle. Samples are sign-extended from SAMPLE_W to OUT_W bits. The outputs hold their values between pulses.
- R7: A frame that ends with fewer than 2×SLOT_W bit clocks sets `sync_err_o` at the bit clock that starts the next frame.
- R8: A frame whose bit-clock count goes past 2×SLOT_W sets `sync_err_o` without waiting for the next frame start.
- R9: `sync_err_o` stays high until `clr_err_i` is asserted. A new error in the same cycle as the clear takes priority.
- R10: After reset, and after any sync error, no `valid_o` pulse is produced until one complete frame of exactly 2×SLOT_W bit clocks has been observed. Pairs from the frames that follow are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select / sync pulse |
| sd_i | input | 1 | External serial data |
| fmt_i | input | 2 | Framing: 0 standard, 1 left-justified, 2 right-justified, 3 short sync |
| clr_err_i | input | 1 | Clears the sticky sync error flag |
| left_o | output | OUT_W | Left sample, sign-extended |
| right_o | output | OUT_W | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |
| sync_err_o | output | 1 | Sticky frame-length error |

## Verification
The bench builds the receiver with SAMPLE_W=8, SLOT_W=12 and OUT_W=16. With these values each frame is 24 bit clocks long, and a right-justified half-frame carries four padding bits, which the bench drives as ones to show that they are discarded. Eight-bit samples with the top bit set make sign extension visible in the upper byte. Frames of 16 and 28 bit clocks exercise the short-frame and long-frame error paths, including the recovery frame that has to be suppressed.

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int OUT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic [1:0]       fmt_i,
  input  logic             clr_err_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             sync_err_o
);

  localparam logic [1:0] FMT_STD = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;
  localparam logic [1:0] FMT_PCM = 2'd3;

  localparam int FRAME = 2 * SLOT_W;
  localparam int PW    = $clog2(FRAME);
  localparam int PX    = PW + 1;

  localparam logic [PW-1:0] LAST   = PW'(FRAME - 1);
  localparam logic [PX-1:0] L_SAMP = PX'(SAMPLE_W);
  localparam logic [PX-1:0] L_SLOT = PX'(SLOT_W);
  localparam logic [PX-1:0] L_OFS  = PX'(SLOT_W - SAMPLE_W);

  logic [2:0] sck_q;
  logic [1:0] ws_q, sd_q;
  logic       ws_p1, ws_p2;
  logic       bit_edge, ws_now, sd_now, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      ws_q  <= {ws_q[0], ws_i};
      sd_q  <= {sd_q[0], sd_i};
    end
  end

  assign bit_edge = sck_q[1] & ~sck_q[2];
  assign ws_now   = ws_q[1];
  assign sd_now   = sd_q[1];

  always_comb begin
    unique case (fmt_i)
      FMT_STD: start = ws_p2 & ~ws_p1;
      FMT_LJ,
      FMT_RJ:  start = ws_p1 & ~ws_now;
      FMT_PCM: start = ~ws_p2 & ws_p1;
      default: start = 1'b0;
    endcase
  end

  logic [PW-1:0] pos, cur;
  logic [PX-1:0] cur_x, lo;
  logic          seen, ovf, armed, err;
  logic          at_end, frame_ok, active, in_l, in_r, last_l, last_r, set_err;
  logic [SAMPLE_W-1:0] sh, sh_next, left_hold;
  logic [OUT_W-1:0]    l_ext, r_ext;

  assign at_end   = (pos == LAST);
  assign frame_ok = seen & ~ovf & at_end;
  assign cur      = start ? '0 : (at_end ? pos : pos + 1'b1);
  assign cur_x    = {1'b0, cur};
  assign lo       = (fmt_i == FMT_RJ) ? L_OFS : '0;
  assign active   = start | (seen & ~ovf & ~at_end);

  assign in_l   = (cur_x >= lo) && (cur_x < lo + L_SAMP);
  assign in_r   = (cur_x >= lo + L_SLOT) && (cur_x < lo + L_SLOT + L_SAMP);
  assign last_l = (cur_x == lo + L_SAMP - PX'(1));
  assign last_r = (cur_x == lo + L_SLOT + L_SAMP - PX'(1));

  assign sh_next = {sh[SAMPLE_W-2:0], sd_now};

  assign set_err = bit_edge & seen & (start ? ~frame_ok : at_end);

  generate
    if (OUT_W > SAMPLE_W) begin : g_ext
      assign l_ext = {{(OUT_W-SAMPLE_W){left_hold[SAMPLE_W-1]}}, left_hold};
      assign r_ext = {{(OUT_W-SAMPLE_W){sh_next[SAMPLE_W-1]}}, sh_next};
    end else begin : g_same
      assign l_ext = left_hold[OUT_W-1:0];
      assign r_ext = sh_next[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_p1     <= 1'b0;
      ws_p2     <= 1'b0;
      pos       <= '0;
      seen      <= 1'b0;
      ovf       <= 1'b0;
      armed     <= 1'b0;
      sh        <= '0;
      left_hold <= '0;
    end else if (bit_edge) begin
      ws_p1 <= ws_now;
      ws_p2 <= ws_p1;
      if (start) begin
        pos   <= '0;
        ovf   <= 1'b0;
        seen  <= 1'b1;
        armed <= seen & frame_ok;
      end else if (seen) begin
        if (at_end) begin
          ovf   <= 1'b1;
          armed <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
      if (active && (in_l || in_r)) sh <= sh_next;
      if (active && in_l && last_l) left_hold <= sh_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_edge && active && in_r && last_r && armed) begin
        left_o  <= l_ext;
        right_o <= r_ext;
        valid_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (set_err)   err <= 1'b1;
    else if (clr_err_i) err <= 1'b0;
  end

  assign sync_err_o = err;

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_err_i,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o,
  input logic             valid_o,
  input logic             sync_err_o,
  input logic             armed,
  input logic             bit_edge
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && !sync_err_o && left_o == '0 && right_o == '0));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R10
  armed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(armed));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err_o && !clr_err_i) |=> sync_err_o);

  // R7 R8
  err_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err_o) |-> $past(bit_edge));

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.OUT_W(OUT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_err_i (clr_err_i),
  .left_o    (left_o),
  .right_o   (right_o),
  .valid_o   (valid_o),
  .sync_err_o(sync_err_o),
  .armed     (armed),
  .bit_edge  (bit_edge)
);

// File: tb/aud_serial_rx_tb_top.sv
module aud_serial_rx_tb_top;

  localparam int CLK_P = 10;
  localparam int SW    = 8;
  localparam int SLOT  = 12;
  localparam int OW    = 16;
  localparam int FR    = 2 * SLOT;
  localparam int HALF  = 4;

  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'h5A, 8'hA5},
    {2'd0, 8'h80, 8'h7F},
    {2'd1, 8'h01, 8'hFE},
    {2'd1, 8'hC3, 8'h3C},
    {2'd2, 8'h96, 8'h69},
    {2'd2, 8'hFF, 8'h00},
    {2'd3, 8'h12, 8'hED},
    {2'd3, 8'h7E, 8'h81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0, clr = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [OW-1:0] left_o, right_o;
  logic valid_o, sync_err_o;

  int nchk = 0, nerr = 0, nval = 0;
  logic [OW-1:0] got_l [64];
  logic [OW-1:0] got_r [64];

  always #(CLK_P/2) clk = ~clk;

  aud_serial_rx #(.SAMPLE_W(SW), .SLOT_W(SLOT), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .fmt_i(fmt), .clr_err_i(clr),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .sync_err_o(sync_err_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (nval < 64) begin
        got_l[nval] = left_o;
        got_r[nval] = right_o;
      end
      nval = nval + 1;
    end
  end

  function automatic logic [OW-1:0] sext(input logic [SW-1:0] x);
    return {{(OW-SW){x[SW-1]}}, x};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic w, input logic d);
    ws = w;
    sd = d;
    repeat (HALF) @(posedge clk);
    #1 sck = 1'b1;
    repeat (HALF) @(posedge clk);
    #1 sck = 1'b0;
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [SW-1:0] l,
                            input logic [SW-1:0] r, input int len);
    for (int i = 0; i < len; i++) begin
      int lo;
      logic w, d;
      lo = (f == 2'd2) ? SLOT - SW : 0;
      case (f)
        2'd0:    w = ((i + 1) % len) >= SLOT;
        2'd3:    w = (i == len - 1);
        default: w = (i >= SLOT);
      endcase
      if (i >= lo && i < lo + SW)                 d = l[SW-1-(i-lo)];
      else if (i >= SLOT + lo && i < SLOT + lo + SW) d = r[SW-1-(i-SLOT-lo)];
      else                                         d = 1'b1;
      bit_out(w, d);
    end
  endtask

  task automatic do_reset(input logic [1:0] f);
    rst_n = 1'b0;
    sck = 1'b0; ws = 1'b0; sd = 1'b0; clr = 1'b0;
    fmt = f;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base;
    do_reset(2'd0);
    chk("R1 valid", 32'(valid_o), 32'd0);
    chk("R1 err", 32'(sync_err_o), 32'd0);
    chk("R1 left", 32'(left_o), 32'd0);
    chk("R1 right", 32'(right_o), 32'd0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] f;
      logic [SW-1:0] l, r;
      string req;
      {f, l, r} = VEC[v];
      req = (f == 2'd0) ? "R2" : (f == 2'd1) ? "R3" : (f == 2'd2) ? "R4" : "R5";
      do_reset(f);
      base = nval;
      send_frame(f, 8'h33, 8'h44, FR);
      send_frame(f, 8'h33, 8'h44, FR);
      chk("R10 no output before a full frame", 32'(nval - base), 32'd0);
      send_frame(f, l, r, FR);
      send_frame(f, 8'h00, 8'h00, FR);
      chk({req, " pair delivered"}, 32'(nval > base), 32'd1);
      chk({req, " left"}, 32'(got_l[base]), 32'(sext(l)));
      chk("R6 right sign-extended", 32'(got_r[base]), 32'(sext(r)));
      chk("R9 no error on clean stream", 32'(sync_err_o), 32'd0);
    end

    // R7 short frame, R10 recovery, R9 sticky and clear
    do_reset(2'd1);
    send_frame(2'd1, 8'h00, 8'h00, FR);
    send_frame(2'd1, 8'h00, 8'h00, FR);
    base = nval;
    send_frame(2'd1, 8'h11, 8'hA2, FR);
    chk("R3 locked pair", 32'(got_r[base]), 32'(sext(8'hA2)));
    chk("R7 no error yet", 32'(sync_err_o), 32'd0);
    send_frame(2'd1, 8'h00, 8'h00, 16);
    base = nval;
    send_frame(2'd1, 8'h55, 8'h66, FR);
    chk("R7 short frame flagged", 32'(sync_err_o), 32'd1);
    chk("R10 frame after error suppressed", 32'(nval - base), 32'd0);
    send_frame(2'd1, 8'h77, 8'h88, FR);
    chk("R10 output resumes", 32'(nval - base), 32'd1);
    chk("R10 resumed left", 32'(got_l[base]), 32'(sext(8'h77)));
    chk("R9 flag sticky", 32'(sync_err_o), 32'd1);
    clr = 1'b1;
    @(posedge clk);
    #1 clr = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 flag cleared", 32'(sync_err_o), 32'd0);

    // R8 long frame
    send_frame(2'd1, 8'h00, 8'h00, 28);
    chk("R8 long frame flagged", 32'(sync_err_o), 32'd1);
    base = nval;
    send_frame(2'd1, 8'h99, 8'h9A, FR);
    chk("R8 frame after overrun suppressed", 32'(nval - base), 32'd0);
    send_frame(2'd1, 8'hE1, 8'h1E, FR);
    chk("R10 output after overrun recovery", 32'(got_r[base]), 32'(sext(8'h1E)));

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule